// File: doc/BRIEF.md
# Parallel Streaming Port Receiver

This block receives an 8-bit parallel byte stream from an external data converter or FPGA. The sender supplies the interface clock. Three optional qualifiers shape the stream:
- a frame-start input,
- a data-valid input,
- a flow-control output that asks the sender to pause.

Each qualifier has its own use bit and polarity bit. Bytes can be taken on the rising edge only (single data rate). They can also be taken on both edges (double data rate). In double-data-rate mode the two bytes of each clock period belong to two interleaved logical channels, and the block steers them apart.

Pin-side samples are registered on the interface clock. A small gray-coded asynchronous FIFO carries them into the system clock domain. There each channel writes its own byte buffer. The two buffers hold 512 bytes together by default.

A consumer sets a window length. When a channel has stored that many bytes, its done flag rises and its write pointer returns to address 0. The consumer reads the bytes through a synchronous read port and then clears the flag. Bytes that arrive for a channel whose window is still pending are dropped, and a sticky overflow flag records the loss. While any window is pending, the flow-control output tells the sender to wait.

The configuration inputs are expected to stay stable while the interface clock is running.

Top module: `pstream_rx`

## Requirements
- R1: In single-data-rate mode (`cfg_ddr`=0), each accepted byte sampled on a rising `port_clk` edge is stored in channel 0. Bytes go to consecutive addresses starting at 0, and channel 1 is never written.
- R2: With `cfg_en_use`=1, a beat is accepted only when `port_enable` equals `cfg_en_pol`. With `cfg_en_use`=0, `port_enable` has no effect and every beat is a candidate.
- R3: With `cfg_start_use`=1, beats are discarded after reset until an enabled beat has `port_start` equal to `cfg_start_pol`. That beat is stored, and every later enabled beat is accepted whatever `port_start` does.
- R4: In double-data-rate mode (`cfg_ddr`=1), the byte sampled on the rising edge goes to channel 0. The byte sampled on the following falling edge goes to channel 1. Both bytes are governed by the qualifiers sampled on the rising edge.
- R5: When a channel has stored `cfg_win_len` bytes (valid range 1 to CH_DEPTH), bit c of `done` (channel c) rises and that channel's write pointer returns to address 0. The bit stays high until a one-cycle pulse on `done_clr` bit c.
- R6: A byte that arrives for a channel whose done bit is set is discarded, and the buffer is left unchanged. A byte refused by a full crossing FIFO is also discarded. Either kind of discard sets `overflow`, which stays high until reset.
- R7: `port_wait` is at level `cfg_wait_pol` while any done bit is set, and otherwise at `~cfg_wait_pol`. With `cfg_wait_use`=0 it stays at `~cfg_wait_pol`.
- R8: `rd_data` shows the byte at channel `rd_ch`, address `rd_addr`, one `sys_clk` cycle after they are presented.
- R9: After reset, `done` is 0, `overflow` is 0 and `port_wait` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ddr | input | 1 | 1 = capture on both edges, two channels |
| cfg_start_use | input | 1 | Enable frame-start gating |
| cfg_start_pol | input | 1 | Active level of port_start |
| cfg_en_use | input | 1 | Enable data-valid qualification |
| cfg_en_pol | input | 1 | Active level of port_enable |
| cfg_wait_use | input | 1 | Enable flow-control output |
| cfg_wait_pol | input | 1 | Active level of port_wait |
| cfg_win_len | input | PW+1 | Bytes per window, 1..CH_DEPTH |
| port_clk | input | 1 | Interface clock from the sender |
| port_data | input | 8 | Parallel data |
| port_start | input | 1 | Frame-start marker |
| port_enable | input | 1 | Data-valid qualifier |
| port_wait | output | 1 | Pause request to the sender |
| rd_ch | input | 1 | Buffer read channel select |
| rd_addr | input | PW | Buffer read address |
| rd_data | output | 8 | Registered buffer read data |
| done_clr | input | 2 | Per-channel window acknowledge pulse |
| done | output | 2 | Per-channel window complete flag |
| overflow | output | 1 | Sticky byte-loss flag |

## Verification
The bench keeps a beat-by-beat model fed from the pins it drives. It targets the following cases:
- Random data-valid gaps. A design that sampled data with the wrong qualifier timing would store idle bytes in the gaps.
- Bytes sent before the frame-start marker. A design that ignored the marker would start the buffer with junk.
- Double-data-rate pairs. A design with the channels swapped or the falling-edge byte from the wrong period would fail the per-address comparison.
- Bytes sent while a window is pending. A design that overwrote the buffer, missed the sticky flag or failed to wrap its pointer would show the wrong byte at address 0 or a wrong flag.
- The flow-control polarity and use settings, checked at the pin.

// File: rtl/pstream_rx.sv
module pstream_rx #(
  parameter int CH_DEPTH = 256,
  parameter int FIFO_AW  = 3,
  localparam int PW = $clog2(CH_DEPTH),
  localparam int WW = PW + 1
) (
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  input  logic          cfg_ddr,
  input  logic          cfg_start_use,
  input  logic          cfg_start_pol,
  input  logic          cfg_en_use,
  input  logic          cfg_en_pol,
  input  logic          cfg_wait_use,
  input  logic          cfg_wait_pol,
  input  logic [WW-1:0] cfg_win_len,
  input  logic          port_clk,
  input  logic [7:0]    port_data,
  input  logic          port_start,
  input  logic          port_enable,
  output logic          port_wait,
  input  logic          rd_ch,
  input  logic [PW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic [1:0]    done_clr,
  output logic [1:0]    done,
  output logic          overflow
);

  localparam int FD = 1 << FIFO_AW;
  localparam int EW = 17;

  function automatic logic [FIFO_AW:0] g2b(input logic [FIFO_AW:0] g);
    logic [FIFO_AW:0] b;
    b[FIFO_AW] = g[FIFO_AW];
    for (int i = FIFO_AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [FIFO_AW:0] b2g(input logic [FIFO_AW:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- interface clock domain ----------------
  logic [1:0]       prst_q;
  logic             prst_n;
  logic [7:0]       fall_byte, a_q;
  logic             acc_q, in_frame;
  logic [FIFO_AW:0] wbin, wgray, rg_s1, rg_s2;
  logic             drop_tgl;
  logic [1:0]       wait_s;
  logic             wait_q;
  logic [EW-1:0]    fmem [FD];

  // sys-domain signals seen by the port side
  logic [FIFO_AW:0] rgray;
  logic             wait_req;

  always_ff @(posedge port_clk or negedge sys_rst_n)
    if (!sys_rst_n) prst_q <= '0;
    else            prst_q <= {prst_q[0], 1'b1};
  assign prst_n = prst_q[1];

  always_ff @(negedge port_clk) fall_byte <= port_data;

  logic en_ok, st_hit, beat_ok, full, near, push, drop;
  logic [FIFO_AW:0] used;
  assign en_ok   = !cfg_en_use || (port_enable == cfg_en_pol);
  assign st_hit  = port_start == cfg_start_pol;
  assign beat_ok = en_ok && (!cfg_start_use || in_frame || st_hit);
  assign full    = wgray == {~rg_s2[FIFO_AW:FIFO_AW-1], rg_s2[FIFO_AW-2:0]};
  assign used    = wbin - g2b(rg_s2);
  assign near    = used >= (FIFO_AW+1)'(FD - 2);
  assign push    = acc_q && !full;
  assign drop    = acc_q && full;

  always_ff @(posedge port_clk or negedge prst_n)
    if (!prst_n) begin
      in_frame <= 1'b0;
      acc_q    <= 1'b0;
      a_q      <= '0;
      wbin     <= '0;
      wgray    <= '0;
      rg_s1    <= '0;
      rg_s2    <= '0;
      drop_tgl <= 1'b0;
      wait_s   <= '0;
      wait_q   <= 1'b0;
    end else begin
      rg_s1  <= rgray;
      rg_s2  <= rg_s1;
      wait_s <= {wait_s[0], wait_req};
      wait_q <= wait_s[1] | near;
      a_q    <= port_data;
      acc_q  <= beat_ok;
      if (cfg_start_use && en_ok && st_hit) in_frame <= 1'b1;
      if (push) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
      if (drop) drop_tgl <= ~drop_tgl;
    end

  always_ff @(posedge port_clk)
    if (push) fmem[wbin[FIFO_AW-1:0]] <= {cfg_ddr, fall_byte, a_q};

  assign port_wait = ~cfg_wait_pol ^ (cfg_wait_use & wait_q);

  // R6
  fifo_hold_chk: assert property (@(posedge port_clk) disable iff (!prst_n)
    (acc_q && full) |=> $stable(wbin));

  // ---------------- system clock domain ----------------
  logic [FIFO_AW:0] rbin, wg_s1, wg_s2;
  logic [2:0]       drop_s;
  logic             ovf;
  logic [1:0]       done_pend;
  logic [PW-1:0]    wp [2];
  logic [7:0]       mem [2][CH_DEPTH];

  logic          pop;
  logic [EW-1:0] ent;
  logic [1:0]    wr_v, wrap;
  logic [7:0]    wr_b [2];

  assign pop     = rgray != wg_s2;
  assign ent     = fmem[rbin[FIFO_AW-1:0]];
  assign wr_v[0] = pop;
  assign wr_v[1] = pop && ent[16];
  assign wr_b[0] = ent[7:0];
  assign wr_b[1] = ent[15:8];
  assign wrap[0] = ({1'b0, wp[0]} + WW'(1)) == cfg_win_len;
  assign wrap[1] = ({1'b0, wp[1]} + WW'(1)) == cfg_win_len;

  always_ff @(posedge sys_clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      wg_s1     <= '0;
      wg_s2     <= '0;
      drop_s    <= '0;
      ovf       <= 1'b0;
      done_pend <= '0;
      wp[0]     <= '0;
      wp[1]     <= '0;
      wait_req  <= 1'b0;
    end else begin
      wg_s1    <= wgray;
      wg_s2    <= wg_s1;
      drop_s   <= {drop_s[1:0], drop_tgl};
      wait_req <= |done_pend;
      if (drop_s[2] ^ drop_s[1]) ovf <= 1'b1;
      if (pop) begin
        rbin  <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
      end
      for (int c = 0; c < 2; c++) begin
        if (done_clr[c]) done_pend[c] <= 1'b0;
        if (wr_v[c]) begin
          if (done_pend[c]) ovf <= 1'b1;
          else if (wrap[c]) begin
            wp[c]        <= '0;
            done_pend[c] <= 1'b1;
          end else wp[c] <= wp[c] + 1'b1;
        end
      end
    end

  always_ff @(posedge sys_clk) begin
    for (int c = 0; c < 2; c++)
      if (wr_v[c] && !done_pend[c]) mem[c][wp[c]] <= wr_b[c];
    rd_data <= mem[rd_ch][rd_addr];
  end

  assign done     = done_pend;
  assign overflow = ovf;

  // R6
  ovf_sticky_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ovf |=> ovf);

  // R5
  done0_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (done_pend[0] && !done_clr[0]) |=> done_pend[0]);

  // R5
  done1_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (done_pend[1] && !done_clr[1]) |=> done_pend[1]);

  // R5
  ptr_rest_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(done_pend[0]) |-> wp[0] == '0);

  // R1
  sdr_ch1_idle_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (pop && !ent[16]) |=> $stable(wp[1]));

endmodule

// File: tb/tb_pstream_rx.sv
module tb_pstream_rx;
  localparam int DEPTH = 256;
  localparam int PW = $clog2(DEPTH);

  logic sys_clk = 0, sys_rst_n = 0;
  logic cfg_ddr = 0, cfg_start_use = 0, cfg_start_pol = 1, cfg_en_use = 1, cfg_en_pol = 1;
  logic cfg_wait_use = 1, cfg_wait_pol = 1;
  logic [PW:0] cfg_win_len = 16;
  logic port_clk = 0, port_start = 0, port_enable = 0;
  logic [7:0] port_data = 0;
  logic port_wait;
  logic rd_ch = 0;
  logic [PW-1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [1:0] done_clr = 0, done;
  logic overflow;

  pstream_rx #(.CH_DEPTH(DEPTH), .FIFO_AW(3)) dut (.*);

  always #10 sys_clk = ~sys_clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  int   exp_mem [2][DEPTH];
  bit   exp_val [2][DEPTH];
  int   m_wp [2];
  bit   m_done [2];
  bit   m_ovf, m_frame, model_on;
  bit   p_v, p_acc, p_ddr;
  logic [7:0] p_a, p_b;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  function automatic void put(input int c, input logic [7:0] v);
    if (m_done[c]) m_ovf = 1;
    else begin
      exp_mem[c][m_wp[c]] = v;
      exp_val[c][m_wp[c]] = 1;
      m_wp[c]++;
      if (m_wp[c] == int'(cfg_win_len)) begin
        m_wp[c] = 0;
        m_done[c] = 1;
      end
    end
  endfunction

  function automatic void model_beat(input logic [7:0] a, input logic [7:0] b,
                                     input logic st, input logic en);
    bit en_ok, sth, acc;
    if (!model_on) return;
    if (p_v && p_acc) begin
      put(0, p_a);
      if (p_ddr) put(1, p_b);
    end
    en_ok = !cfg_en_use || (en == cfg_en_pol);
    sth = (st == cfg_start_pol);
    acc = en_ok && (!cfg_start_use || m_frame || sth);
    if (cfg_start_use && en_ok && sth) m_frame = 1;
    p_v = 1; p_acc = acc; p_a = a; p_b = b; p_ddr = cfg_ddr;
  endfunction

  function automatic void model_clear();
    for (int c = 0; c < 2; c++) begin
      m_wp[c] = 0; m_done[c] = 0;
      for (int i = 0; i < DEPTH; i++) exp_val[c][i] = 0;
    end
    m_ovf = 0; m_frame = 0; p_v = 0;
  endfunction

  task automatic pbeat(input logic [7:0] a, input logic [7:0] b, input logic st, input logic en);
    port_data = a; port_start = st; port_enable = en;
    #10 port_clk = 1;
    #10 port_data = b;
    #10 port_clk = 0;
    #10;
    model_beat(a, b, st, en);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      pbeat(8'($urandom), 8'($urandom), ~cfg_start_pol, ~cfg_en_pol);
  endtask

  task automatic send_acc(input int n, input int maxgap);
    for (int i = 0; i < n; i++) begin
      idle($urandom % (maxgap + 1));
      pbeat(8'($urandom), 8'($urandom), ~cfg_start_pol, cfg_en_pol);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic flush();
    idle(3);
    wait_sys(12);
  endtask

  task automatic do_reset();
    model_on = 0;
    cfg_ddr = 0; cfg_start_use = 0; cfg_en_use = 1; cfg_en_pol = 1;
    cfg_start_pol = 1; cfg_wait_use = 1; cfg_wait_pol = 1;
    @(negedge sys_clk) sys_rst_n = 0;
    idle(3);
    @(negedge sys_clk) sys_rst_n = 1;
    idle(3);
    wait_sys(4);
    model_clear();
    model_on = 1;
  endtask

  task automatic rd_check(input string req, input int c, input int addr, input int exp);
    @(negedge sys_clk);
    rd_ch = c[0]; rd_addr = PW'(addr);
    @(negedge sys_clk);
    chk(req, {24'd0, rd_data}, exp[31:0]);
  endtask

  task automatic cmp_chan(input string req, input int c, input int n);
    for (int i = 0; i < n; i++)
      if (exp_val[c][i]) rd_check(req, c, i, exp_mem[c][i]);
  endtask

  task automatic chk_flags(input string req);
    chk({req, " done"}, {30'd0, done}, {30'd0, m_done[1], m_done[0]});
    chk({req, " overflow"}, {31'd0, overflow}, {31'd0, m_ovf});
  endtask

  task automatic clr_done(input logic [1:0] m);
    @(negedge sys_clk) done_clr = m;
    @(negedge sys_clk) done_clr = 0;
    if (m[0]) m_done[0] = 0;
    if (m[1]) m_done[1] = 0;
  endtask

  initial begin
    int a0;
    void'($urandom(32'd7103));
    do_reset();

    // R9 reset state
    chk("R9 done", {30'd0, done}, 0);
    chk("R9 overflow", {31'd0, overflow}, 0);
    chk("R9 wait", {31'd0, port_wait}, 0);

    // R1 / R2: SDR with random valid gaps
    cfg_win_len = 16;
    send_acc(16, 2);
    flush();
    chk_flags("R5 sdr window");
    chk("R1 ch1 unused", {31'd0, done[1]}, 0);
    cmp_chan("R1 R2 sdr data", 0, 16);

    // R7 wait pin
    idle(6);
    chk("R7 wait active high", {31'd0, port_wait}, 1);
    cfg_wait_pol = 0; #1;
    chk("R7 wait active low", {31'd0, port_wait}, 0);
    cfg_wait_use = 0; #1;
    chk("R7 wait unused", {31'd0, port_wait}, 1);
    cfg_wait_use = 1; cfg_wait_pol = 1; #1;

    // R6 overflow while pending
    a0 = exp_mem[0][0];
    send_acc(3, 0);
    flush();
    chk_flags("R6 drop pending");
    chk("R6 ovf set", {31'd0, overflow}, 1);
    rd_check("R6 buffer kept", 0, 0, a0);

    // R5 clear and wrap
    clr_done(2'b01);
    idle(6);
    wait_sys(4);
    chk("R5 done cleared", {30'd0, done}, 0);
    chk("R7 wait released", {31'd0, port_wait}, 0);
    chk("R6 ovf sticky", {31'd0, overflow}, 1);
    cfg_win_len = 8;
    send_acc(8, 1);
    flush();
    chk_flags("R5 second window");
    cmp_chan("R5 wrap data", 0, 8);

    // R3 frame start gating, active low start
    do_reset();
    cfg_start_use = 1; cfg_start_pol = 0; cfg_win_len = 8;
    for (int i = 0; i < 5; i++) pbeat(8'($urandom), 8'h00, 1'b1, 1'b1);
    pbeat(8'hA5, 8'h00, 1'b0, 1'b1);
    send_acc(7, 1);
    flush();
    chk_flags("R3 frame");
    rd_check("R3 first byte", 0, 0, 8'hA5);
    cmp_chan("R3 frame data", 0, 8);

    // R4 DDR interleave, enable active low
    do_reset();
    cfg_ddr = 1; cfg_en_pol = 0; cfg_win_len = 10;
    send_acc(10, 2);
    flush();
    chk_flags("R4 ddr");
    chk("R4 both done", {30'd0, done}, 3);
    cmp_chan("R4 ch0", 0, 10);
    cmp_chan("R4 ch1", 1, 10);
    rd_check("R8 read ch1 addr9", 1, 9, exp_mem[1][9]);

    // R2 enable ignored
    clr_done(2'b11);
    cfg_ddr = 0; cfg_win_len = 6; cfg_en_use = 0;
    for (int i = 0; i < 6; i++) pbeat(8'($urandom), 8'h00, ~cfg_start_pol, ~cfg_en_pol);
    flush();
    chk_flags("R2 enable ignored");
    cmp_chan("R2 enable ignored data", 0, 6);

    finish_run();
  end
endmodule